// File: doc/BRIEF.md
# UART transmitter with fractional stop

This block is the transmit half of a serial port. A tick generator divides the system clock by two and then by one plus a programmable divisor, giving a tick at thirty-two times the bit rate. Characters written into a sixteen-entry queue are sent one at a time. Each character is a low start bit, then five to eight data bits with the least significant bit first, then an optional parity bit, then a high stop period. The stop period is set in eighths of a bit time.

The line can be forced low for a break, which starts and ends only between characters. A loopback switch sends the serial stream to a side output meant for a receiver and holds the pin high. The queue can be cleared and reports its fill level. An interrupt stays high while that level is below a programmable threshold.

Top module: `sertx_core`

## Requirements
- R1: A tick occurs once every 2*(1+baud_div) clock cycles, and every start, data and parity bit lasts 32 ticks.
- R2: A character begins with one low start bit. Data bits follow least significant bit first. The line rests high between characters and changes level only in the cycle after a tick.
- R3: char_len sets the number of data bits: 0 = 5, 1 = 6, 2 = 7, 3 = 8. Upper data bits beyond that length are not sent.
- R4: When par_en is 1, one parity bit follows the data. With par_even = 1, the data bits plus the parity bit hold an even number of ones. With par_even = 0, they hold an odd number.
- R5: The stop period lasts (stop_len+1)*4 ticks. When another character is waiting, its start bit follows at once, so one character spans ((1+bits+parity)*32 + (stop_len+1)*4) ticks from start to start.
- R6: While brk_req is 1, the line is driven low from the next character boundary on. A character already in progress finishes intact. The line returns high once brk_req is 0.
- R7: The queue holds 16 characters. fifo_level reports how many are held. wr_ready is 0 when the queue is full, and a write while full is dropped without changing the level.
- R8: A fifo_clr pulse empties the queue, and fifo_level reads 0 in the next cycle.
- R9: tx_irq is 1 exactly when fifo_level is less than tx_thresh.
- R10: With lpbk_en = 1, the serial stream appears on lpbk_out and txd stays high. With lpbk_en = 0, lpbk_out stays high.
- R11: With baud_en = 0 no ticks occur and no character starts. With tx_en = 0 no new character starts and the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_en | input | 1 | Enables the tick generator |
| baud_div | input | 16 | Divisor; tick period is 2*(1+baud_div) clocks |
| tx_en | input | 1 | Allows new characters to start |
| par_en | input | 1 | Adds a parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| brk_req | input | 1 | Requests a break (line low) |
| char_len | input | 2 | Data length code, 5 to 8 bits |
| stop_len | input | 4 | Stop period in eighths of a bit, minus one |
| fifo_clr | input | 1 | Empties the transmit queue |
| tx_thresh | input | 4 | Level threshold for the interrupt |
| wr_valid | input | 1 | Write strobe into the queue |
| wr_data | input | 8 | Character to queue |
| wr_ready | output | 1 | Queue has room |
| fifo_level | output | 5 | Number of queued characters |
| tx_irq | output | 1 | Level below threshold |
| lpbk_en | input | 1 | Routes the stream to lpbk_out |
| txd | output | 1 | Serial output pin |
| lpbk_out | output | 1 | Looped-back serial stream |

## Verification
Some properties are checked on every cycle. Ticks are never back to back, and none appear while the generator is disabled. The framer's line changes only right after a tick. The queue level never goes above its depth and never moves by more than one, except on a clear, which empties it. The pin stays high under loopback. Other behaviour only the scenarios can show: the decoded content of each frame, parity polarity, exact start-to-start spans for several stop settings and divisors, break timing around a character in flight, and the interrupt against the threshold.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_DATA,
      S_PAR,
      S_STOP,
      S_BRK
   } fr_state_t;

   // ticks per bit minus one, and ticks per eighth of a bit
   localparam logic [5:0] BIT_LAST   = 6'd31;
   localparam int         STEP_TICKS = 4;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int CW = DIV_W + 1;

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("sertx_baud: DIV_W must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   // last count of a 2*(div+1) cycle period
   assign lim = {div, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt == lim) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic [DW-1:0]              din,
   input  logic                       pop,
   output logic [DW-1:0]              dout,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] level
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("sertx_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full && !clr;
   assign do_pop  = pop && !empty && !clr;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
   import sertx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       tx_en,
   input  logic       par_en,
   input  logic       par_even,
   input  logic       brk_req,
   input  logic [1:0] char_len,
   input  logic [3:0] stop_len,
   input  logic       q_empty,
   input  logic [7:0] q_data,
   output logic       pop,
   output logic       line
);
   fr_state_t  st;
   logic [5:0] tcnt;
   logic [2:0] bcnt;
   logic [2:0] nb_last;
   logic [7:0] sh;
   logic       par_q, pen_q;
   logic [3:0] stp_q;

   logic [5:0] stop_last;
   logic       bit_end, stop_done, at_bound, want_chr;
   logic [7:0] dmask, dmasked;

   assign stop_last = {stp_q, 2'b11};  // (n+1)*STEP_TICKS - 1
   assign bit_end   = (tcnt == BIT_LAST);
   assign stop_done = (st == S_STOP) && (tcnt == stop_last);
   assign at_bound  = (st == S_IDLE) || stop_done;
   assign want_chr  = !brk_req && tx_en && !q_empty;
   assign pop       = tick && at_bound && want_chr;
   assign dmask     = 8'hFF >> (2'd3 - char_len);
   assign dmasked   = q_data & dmask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         tcnt    <= '0;
         bcnt    <= '0;
         nb_last <= '0;
         sh      <= '0;
         par_q   <= 1'b0;
         pen_q   <= 1'b0;
         stp_q   <= '0;
      end else if (tick) begin
         case (st)
            S_IDLE, S_STOP: begin
               if (st == S_STOP && !stop_done) begin
                  tcnt <= tcnt + 1'b1;
               end else if (brk_req) begin
                  st <= S_BRK;
               end else if (want_chr) begin
                  st      <= S_START;
                  tcnt    <= '0;
                  sh      <= dmasked;
                  nb_last <= {1'b1, char_len};
                  par_q   <= (^dmasked) ^ ~par_even;
                  pen_q   <= par_en;
                  stp_q   <= stop_len;
               end else begin
                  st <= S_IDLE;
               end
            end
            S_START: begin
               if (bit_end) begin
                  st   <= S_DATA;
                  tcnt <= '0;
                  bcnt <= '0;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            S_DATA: begin
               if (bit_end) begin
                  tcnt <= '0;
                  sh   <= sh >> 1;
                  if (bcnt == nb_last) st <= pen_q ? S_PAR : S_STOP;
                  else                 bcnt <= bcnt + 1'b1;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            S_PAR: begin
               if (bit_end) begin
                  st   <= S_STOP;
                  tcnt <= '0;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            S_BRK: begin
               if (!brk_req) st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st)
         S_START: line = 1'b0;
         S_DATA:  line = sh[0];
         S_PAR:   line = par_q;
         S_BRK:   line = 1'b0;
         default: line = 1'b1;
      endcase
   end
endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
   parameter int DIV_W   = 16,
   parameter int DEPTH   = 16,
   parameter int TH_W    = 4,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       baud_en,
   input  logic [DIV_W-1:0]           baud_div,
   input  logic                       tx_en,
   input  logic                       par_en,
   input  logic                       par_even,
   input  logic                       brk_req,
   input  logic [1:0]                 char_len,
   input  logic [3:0]                 stop_len,
   input  logic                       fifo_clr,
   input  logic [TH_W-1:0]            tx_thresh,
   input  logic                       wr_valid,
   input  logic [7:0]                 wr_data,
   output logic                       wr_ready,
   output logic [$clog2(DEPTH+1)-1:0] fifo_level,
   output logic                       tx_irq,
   input  logic                       lpbk_en,
   output logic                       txd,
   output logic                       lpbk_out
);
   generate
      if (TH_W < 1 || TH_W > 16) begin : g_bad_th
         $error("sertx_core: TH_W out of range");
      end
   endgenerate

   logic       tick_w, line_w, pop_w, empty_w, full_w;
   logic [7:0] qdata_w;
   logic       below_w;

   sertx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .en(baud_en), .div(baud_div), .tick(tick_w)
   );

   sertx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(wr_valid), .din(wr_data),
      .pop(pop_w), .dout(qdata_w), .empty(empty_w), .full(full_w),
      .level(fifo_level)
   );

   sertx_framer u_framer (
      .clk(clk), .rst_n(rst_n), .tick(tick_w), .tx_en(tx_en), .par_en(par_en),
      .par_even(par_even), .brk_req(brk_req), .char_len(char_len),
      .stop_len(stop_len), .q_empty(empty_w), .q_data(qdata_w), .pop(pop_w),
      .line(line_w)
   );

   assign wr_ready = !full_w;
   assign below_w  = int'(fifo_level) < int'(tx_thresh);

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk) begin
            if (!rst_n) tx_irq <= 1'b0;
            else        tx_irq <= below_w;
         end
      end else begin : g_irq_comb
         assign tx_irq = below_w;
      end
   endgenerate

   assign txd      = lpbk_en ? 1'b1 : line_w;
   assign lpbk_out = lpbk_en ? line_w : 1'b1;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
   parameter int DEPTH = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       tick,
   input logic                       line,
   input logic                       txd,
   input logic                       lpbk_en,
   input logic                       baud_en,
   input logic                       fifo_clr,
   input logic [$clog2(DEPTH+1)-1:0] level
);
   // R1
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R11
   tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_en |=> !tick);

   // R2
   line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line != $past(line)) |-> $past(tick));

   // R7
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) <= DEPTH);

   // R7
   level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_clr |=> (int'(level) == int'($past(level))
                  || int'(level) == int'($past(level)) + 1
                  || int'(level) + 1 == int'($past(level))));

   // R8
   clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |=> (level == '0));

   // R10
   loop_pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lpbk_en |-> txd);
endmodule

bind sertx_core sertx_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick_w), .line(line_w), .txd(txd),
   .lpbk_en(lpbk_en), .baud_en(baud_en), .fifo_clr(fifo_clr),
   .level(fifo_level)
);

// File: tb/sertx_core_test.sv
module sertx_core_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        baud_en = 1'b0;
   logic [15:0] baud_div = '0;
   logic        tx_en = 1'b0, par_en = 1'b0, par_even = 1'b0, brk_req = 1'b0;
   logic [1:0]  char_len = 2'd3;
   logic [3:0]  stop_len = 4'd7;
   logic        fifo_clr = 1'b0;
   logic [3:0]  tx_thresh = '0;
   logic        wr_valid = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        lpbk_en = 1'b0;
   logic        wr_ready, tx_irq, txd, lpbk_out;
   logic [4:0]  fifo_level;

   sertx_core uut (
      .clk(clk), .rst_n(rst_n), .baud_en(baud_en), .baud_div(baud_div),
      .tx_en(tx_en), .par_en(par_en), .par_even(par_even), .brk_req(brk_req),
      .char_len(char_len), .stop_len(stop_len), .fifo_clr(fifo_clr),
      .tx_thresh(tx_thresh), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .fifo_level(fifo_level), .tx_irq(tx_irq),
      .lpbk_en(lpbk_en), .txd(txd), .lpbk_out(lpbk_out)
   );

   always #(CLK_P/2) clk = ~clk;

   typedef struct {
      logic [7:0] d;
      int         nb;
      bit         pe;
      bit         ev;
   } item_t;

   item_t exp_q[$];
   int    falls[$];
   int    cyc = 0;
   int    bit_clks = 64;
   int    tests = 0, fails = 0;
   int    lb_err = 0;
   bit    done = 1'b0;
   logic  mon_line;

   assign mon_line = lpbk_en ? lpbk_out : txd;

   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (rst_n && lpbk_en && txd == 1'b0) lb_err++;

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   // driver: queue the expectation, then write the character
   task automatic send(input logic [7:0] d);
      item_t it;
      it.nb = 5 + int'(char_len);
      it.d  = d & 8'((1 << it.nb) - 1);
      it.pe = par_en;
      it.ev = par_even;
      exp_q.push_back(it);
      wr(d);
   endtask

   task automatic drain();
      while (exp_q.size() > 0) @(negedge clk);
      repeat (20) @(negedge clk);
   endtask

   // monitor: decode each frame and compare with the queue head
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && exp_q.size() > 0 && mon_line == 1'b0) begin : dec
            item_t      it;
            logic [7:0] got;
            int         bc;
            it  = exp_q[0];
            bc  = bit_clks;
            got = '0;
            falls.push_back(cyc);
            repeat (bc/2) @(negedge clk);
            chk("R2 start bit low", int'(mon_line), 0);
            for (int i = 0; i < it.nb; i++) begin
               repeat (bc) @(negedge clk);
               got[i] = mon_line;
            end
            chk("R3 data bits", int'(got), int'(it.d));
            if (it.pe) begin
               repeat (bc) @(negedge clk);
               chk("R4 parity bit", int'(mon_line), int'((^it.d) ^ !it.ev));
            end
            repeat (bc/2 + 2) @(negedge clk);
            chk("R5 stop high", int'(mon_line), 1);
            exp_q.delete(0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R2 reset txd", int'(txd), 1);
      chk("R7 reset level", int'(fifo_level), 0);
      chk("R7 reset wr_ready", int'(wr_ready), 1);
      chk("R9 reset irq", int'(tx_irq), 0);
      chk("R10 reset lpbk_out", int'(lpbk_out), 1);

      // R7 R8 R9 R11: queue with transmit disabled
      baud_en   = 1'b1;
      tx_thresh = 4'd4;
      for (int i = 0; i < 3; i++) wr(8'(i));
      chk("R7 level 3", int'(fifo_level), 3);
      chk("R9 irq below threshold", int'(tx_irq), 1);
      wr(8'h11); wr(8'h22);
      chk("R9 irq at/above threshold", int'(tx_irq), 0);
      for (int i = 0; i < 11; i++) wr(8'(i));
      chk("R7 full level", int'(fifo_level), 16);
      chk("R7 full wr_ready", int'(wr_ready), 0);
      wr(8'hEE);
      chk("R7 write while full dropped", int'(fifo_level), 16);
      chk("R11 tx_en low keeps line high", int'(txd), 1);
      @(negedge clk); fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
      chk("R8 clear empties", int'(fifo_level), 0);
      chk("R9 irq after clear", int'(tx_irq), 1);
      tx_thresh = 4'd0;
      @(negedge clk);
      chk("R9 irq with zero threshold", int'(tx_irq), 0);

      // R2 R3: 8N1, back to back
      tx_en = 1'b1;
      send(8'hA5); send(8'h3C);
      drain();
      // R3: shorter lengths, upper bits dropped
      char_len = 2'd0; send(8'hFA); drain();
      char_len = 2'd2; send(8'h81); drain();
      // R4: parity both polarities
      char_len = 2'd1; par_en = 1'b1; par_even = 1'b1; send(8'h2B); drain();
      par_even = 1'b0; send(8'h2B); send(8'h00); drain();

      // R5: start-to-start span, shortest stop
      par_en = 1'b0; char_len = 2'd3; stop_len = 4'd0;
      falls.delete();
      send(8'h5A); send(8'hC3); drain();
      chk("R5 span stop 1/8", falls[1] - falls[0], (9*32 + 4) * 2);
      // R5 R4: longest stop with parity, 5 bits
      char_len = 2'd0; par_en = 1'b1; par_even = 1'b1; stop_len = 4'd15;
      falls.delete();
      send(8'h13); send(8'h0C); drain();
      chk("R5 span two stop bits", falls[1] - falls[0], (7*32 + 64) * 2);

      // R1: divisor 2
      par_en = 1'b0; char_len = 2'd3; stop_len = 4'd7;
      baud_div = 16'd2; bit_clks = 64 * 3;
      repeat (20) @(negedge clk);
      falls.delete();
      send(8'h69); send(8'h96); drain();
      chk("R1 span with divisor 2", falls[1] - falls[0], (9*32 + 32) * 6);
      baud_div = 16'd0; bit_clks = 64;
      repeat (20) @(negedge clk);

      // R11: generator disabled holds the queue
      baud_en = 1'b0;
      send(8'h7E);
      repeat (500) @(negedge clk);
      chk("R11 baud off no start level", int'(fifo_level), 1);
      chk("R11 baud off line high", int'(txd), 1);
      baud_en = 1'b1;
      drain();

      // R6: break raised mid-character
      send(8'h55);
      repeat (300) @(negedge clk);
      brk_req = 1'b1;
      drain();
      repeat (100) @(negedge clk);
      chk("R6 break holds line low", int'(txd), 0);
      brk_req = 1'b0;
      repeat (10) @(negedge clk);
      chk("R6 break released", int'(txd), 1);

      // R10: loopback
      lpbk_en = 1'b1;
      repeat (10) @(negedge clk);
      lb_err = 0;
      send(8'h96); drain();
      chk("R10 pin high during loopback", lb_err, 0);
      lpbk_en = 1'b0;
      repeat (10) @(negedge clk);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule